// File: doc/BRIEF.md
# Redundant Clock Role Arbiter

This block decides whether a clock module in a redundant pair drives timing as the master or follows its mate as the slave. The role request normally comes from a single input pin that also carries the frame signal of the serial configuration bus. Because the pin toggles during ordinary bus traffic, a new pin level counts as a request only after it has stayed unchanged for a long window with no serial clock activity. When register control is selected, a register bit forms the request instead and the pin is ignored.

A slave role is taken only while the mate clock input is flagged valid. The role falls back to master as soon as that flag drops. Alongside the role, the block reports a 4-bit status code for the secondary loop. The code walks through frequency acquisition, phase acquisition and tracking after every role entry, with separate code ranges for master and slave.

Top module: `clk_role_arbiter`

## Requirements
- R1: After reset the role is master (`role_slave_o` = 0). `sec_status_o` reads 0000 (not locked) while reset is held and 0001 from the first cycle after reset.
- R2: The role changes from master to slave only when the effective request is slave and `mate_valid_i` is 1. A slave request while `mate_valid_i` is 0 leaves the role at master, and the role becomes slave one cycle after the flag rises.
- R3: From slave, the role returns to master one cycle after the effective request becomes master or `mate_valid_i` drops to 0.
- R4: With `reg_sel_i` = 0, a pin level becomes the request once the synchronized pin has held it for more than `HOLD_CYCLES` clock cycles with no serial clock edge in that window. A low pin requests slave and a high pin requests master.
- R5: A pin level held for fewer than `HOLD_CYCLES` cycles has no effect. Any synchronized serial clock edge restarts the window, so a level held during bus activity has no effect.
- R6: With `reg_sel_i` = 1, the pin is ignored. `reg_slave_i` = 1 requests slave and `reg_slave_i` = 0 requests master.
- R7: On each role entry the loop stage restarts. Frequency acquisition lasts `STAGE_CYCLES` cycles, then phase acquisition lasts `STAGE_CYCLES` cycles, then tracking holds. The status codes are 0001, 0010 and 0011 as master, and 0100, 0101 and 0110 as slave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pin_i | input | 1 | Shared role/frame pin, asynchronous |
| sclk_i | input | 1 | Serial bus clock, asynchronous |
| reg_sel_i | input | 1 | 1 selects register control of the role |
| reg_slave_i | input | 1 | Register role bit, 1 requests slave |
| mate_valid_i | input | 1 | Mate clock input is present and in range |
| role_slave_o | output | 1 | 1 when the role is slave |
| sec_status_o | output | 4 | Secondary loop status code |

## Verification
The assertions assume that `reg_sel_i`, `reg_slave_i` and `mate_valid_i` are synchronous to `clk`. The pin and the serial clock may arrive from any domain, because both pass through synchronizers. The stimulus changes every input one time unit after a rising edge and samples on falling edges. Pulse-length sweeps leave out the few cycles around the acceptance threshold that the synchronizer latency makes uncertain, so each checked length is clearly below or clearly above the window.

// File: rtl/clk_role_pkg.sv
package clk_role_pkg;

    typedef enum logic [1:0] {
        STG_NONE  = 2'd0,
        STG_FREQ  = 2'd1,
        STG_PHASE = 2'd2,
        STG_TRACK = 2'd3
    } loop_stage_e;

    localparam logic [3:0] SLAVE_CODE_BASE = 4'd3;

    function automatic logic [3:0] status_code(input logic slave, input loop_stage_e stg);
        if (stg == STG_NONE) return 4'd0;
        return (slave ? SLAVE_CODE_BASE : 4'd0) + {2'b00, stg};
    endfunction

endpackage

// File: rtl/clk_role_sync.sv
module clk_role_sync #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.meta   <= {WIDTH{RST_VAL}};
            s_q.stable <= {WIDTH{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/clk_role_pin_qual.sv
module clk_role_pin_qual #(
    parameter int HOLD_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s_i,
    input  logic sclk_s_i,
    output logic level_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          pin_prev;
        logic          sclk_prev;
        logic          acc;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t q_d, q_q;
    logic  sclk_edge, pin_edge;

    always_comb begin
        q_d           = q_q;
        q_d.pin_prev  = pin_s_i;
        q_d.sclk_prev = sclk_s_i;
        sclk_edge     = sclk_s_i != q_q.sclk_prev;
        pin_edge      = pin_s_i != q_q.pin_prev;
        if (sclk_edge || pin_edge) begin
            q_d.cnt = '0;
        end else if (pin_s_i != q_q.acc) begin
            if (q_q.cnt == LAST) begin
                q_d.acc = pin_s_i;
                q_d.cnt = '0;
            end else begin
                q_d.cnt = q_q.cnt + 1'b1;
            end
        end else begin
            q_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.pin_prev  <= 1'b1;
            q_q.sclk_prev <= 1'b0;
            q_q.acc       <= 1'b1;
            q_q.cnt       <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign level_o = q_q.acc;

    // R4
    acc_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != $past(level_o)) |-> ($past(pin_s_i) == level_o));

    // R5
    acc_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != $past(level_o)) |-> ($past(sclk_s_i) == $past(q_q.sclk_prev)));
endmodule

// File: rtl/clk_role_fsm.sv
module clk_role_fsm
    import clk_role_pkg::*;
#(
    parameter int STAGE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_slave_i,
    input  logic       mate_valid_i,
    output logic       slave_o,
    output logic [3:0] status_o
);
    localparam int DW = $clog2(STAGE_CYCLES + 1);
    localparam logic [DW-1:0] DWELL_LAST = DW'(STAGE_CYCLES - 1);

    typedef struct packed {
        logic          slave;
        loop_stage_e   stage;
        logic [DW-1:0] dwell;
    } role_t;

    role_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.slave = req_slave_i && mate_valid_i;
        if (r_d.slave != r_q.slave) begin
            r_d.stage = STG_FREQ;
            r_d.dwell = '0;
        end else begin
            unique case (r_q.stage)
                STG_NONE: begin
                    r_d.stage = STG_FREQ;
                    r_d.dwell = '0;
                end
                STG_FREQ, STG_PHASE: begin
                    if (r_q.dwell == DWELL_LAST) begin
                        r_d.stage = (r_q.stage == STG_FREQ) ? STG_PHASE : STG_TRACK;
                        r_d.dwell = '0;
                    end else begin
                        r_d.dwell = r_q.dwell + 1'b1;
                    end
                end
                default: r_d.dwell = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.slave <= 1'b0;
            r_q.stage <= STG_NONE;
            r_q.dwell <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign slave_o  = r_q.slave;
    assign status_o = status_code(r_q.slave, r_q.stage);

    // R2
    slave_needs_mate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slave_o) |-> $past(req_slave_i && mate_valid_i));

    // R3
    mate_loss_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_o && !mate_valid_i) |=> !slave_o);

    // R7
    slave_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_o |-> (status_o >= 4'd4 && status_o <= 4'd6));

    // R7
    role_entry_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_o != $past(slave_o)) |-> (status_o == 4'd1 || status_o == 4'd4));
endmodule

// File: rtl/clk_role_arbiter.sv
module clk_role_arbiter #(
    parameter int HOLD_CYCLES  = 25_000_000,
    parameter int STAGE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_pin_i,
    input  logic       sclk_i,
    input  logic       reg_sel_i,
    input  logic       reg_slave_i,
    input  logic       mate_valid_i,
    output logic       role_slave_o,
    output logic [3:0] sec_status_o
);
    logic pin_s, sclk_s, pin_level, req_slave;

    clk_role_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(frame_pin_i), .sync_o(pin_s));

    clk_role_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk_i), .sync_o(sclk_s));

    clk_role_pin_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .sclk_s_i(sclk_s), .level_o(pin_level));

    assign req_slave = reg_sel_i ? reg_slave_i : ~pin_level;

    clk_role_fsm #(.STAGE_CYCLES(STAGE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_slave_i(req_slave), .mate_valid_i(mate_valid_i),
        .slave_o(role_slave_o), .status_o(sec_status_o));

    // R6
    reg_slave_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i && reg_slave_i && mate_valid_i) |=> role_slave_o);

    // R6
    reg_master_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i && !reg_slave_i) |=> !role_slave_o);
endmodule

// File: tb/clk_role_arbiter_tb.sv
module clk_role_arbiter_tb;
    localparam int HOLD  = 40;
    localparam int STAGE = 12;

    logic clk = 1'b0;
    logic rst_n, pin, sclk, rsel, rslave, mate;
    logic       slave;
    logic [3:0] status;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    clk_role_arbiter #(.HOLD_CYCLES(HOLD), .STAGE_CYCLES(STAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_pin_i(pin), .sclk_i(sclk),
        .reg_sel_i(rsel), .reg_slave_i(rslave), .mate_valid_i(mate),
        .role_slave_o(slave), .sec_status_o(status));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        @(negedge clk);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_role(input string req, input logic exp);
        @(negedge clk);
        checks++;
        if (slave !== exp) begin
            fails++;
            $display("FAIL %s role actual=%0d expected=%0d", req, slave, exp);
        end
    endtask

    task automatic check_status(input string req, input int exp);
        @(negedge clk);
        checks++;
        if (status !== 4'(exp)) begin
            fails++;
            $display("FAIL %s status actual=%0d expected=%0d", req, status, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin = 1'b1; sclk = 1'b0; rsel = 1'b0; rslave = 1'b0; mate = 1'b1;
        step(4);
        check_role("R1 reset role", 1'b0);
        check_status("R1 reset status", 0);
        rst_n = 1'b1;
        step(2);
        check_status("R1 first status", 1);
        step(2 * STAGE + 4);
        check_status("R7 master tracking", 3);

        // pin low held long, mate valid -> slave
        pin = 1'b0;
        step(HOLD + 12);
        check_role("R4 pin low accepted", 1'b1);
        check_status("R7 slave freq", 4);
        step(STAGE);
        check_status("R7 slave phase", 5);
        step(2 * STAGE);
        check_status("R7 slave tracking", 6);

        // short high pulse ignored
        pin = 1'b1;
        step(HOLD - 8);
        pin = 1'b0;
        step(HOLD + 12);
        check_role("R5 short pulse", 1'b1);

        // high level with bus activity ignored
        pin = 1'b1;
        for (int i = 0; i < (HOLD + 30) / 8; i++) begin
            step(8);
            sclk = ~sclk;
        end
        check_role("R5 sclk activity", 1'b1);
        step(HOLD + 12);
        check_role("R3 pin high accepted", 1'b0);
        check_status("R7 master reentry freq", 1);

        // slave request without valid mate
        mate = 1'b0;
        pin  = 1'b0;
        step(HOLD + 12);
        check_role("R2 no mate stays master", 1'b0);
        mate = 1'b1;
        step(1);
        check_role("R2 mate arrives", 1'b1);
        mate = 1'b0;
        step(1);
        check_role("R3 mate lost", 1'b0);
        mate = 1'b1;
        step(1);
        check_role("R2 mate back", 1'b1);
        pin = 1'b1;
        step(HOLD + 12);
        check_role("R3 request master", 1'b0);

        // register control
        rsel = 1'b1; rslave = 1'b1;
        step(1);
        check_role("R6 reg slave", 1'b1);
        pin = 1'b0;
        step(HOLD + 12);
        rslave = 1'b0;
        step(1);
        check_role("R6 reg master pin ignored", 1'b0);
        pin = 1'b1;
        step(HOLD + 12);
        rsel = 1'b0;
        step(2);
        check_role("R6 back to pin control", 1'b0);

        // pulse length sweep
        for (int len = 4; len <= HOLD + 20; len += 4) begin
            if (len >= HOLD - 3 && len <= HOLD + 4) continue;
            pin = 1'b0;
            step(len);
            pin = 1'b1;
            step(4);
            check("R4 R5 sweep", int'(slave), (len > HOLD + 4) ? 1 : 0);
            step(HOLD + 12);
            check_role("R4 sweep return", 1'b0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule